// File: doc/BRIEF.md
# Peripheral Clock Enable Sequencer

This block owns a bank of peripheral clock-stop bits and the peripheral reset bits tied to them, and runs the enable sequence in hardware. Software pulses a per-channel enable or disable strobe. The block holds these strobes as pending work and serves them one at a time. It drives a clock-stop word and a reset word toward the gating cells and the peripheral resets. It also reports, per channel, whether the clock is currently running.

A static per-channel table is set by parameters. A mask marks the channels that own a reset bit. For such a channel the reset bit index is `(ch*RST_STEP + RST_OFS) mod NCH`. A second mask marks channels whose stop bit has inverted meaning. For a channel with a linked reset, enabling first puts the peripheral into reset, then waits a short delay, then ungates the clock. It then waits a long delay before it releases the reset. A disable only touches the stop bit. The two delays are counted in cycles of the block clock and are set by parameters.

Top module: `pces_seq`

## Requirements
- R1: A synchronous reset sets every normal-polarity stop bit to 1 and every inverted stop bit to 0. It sets the reset bit of every linked channel (bit `(7*ch+3) mod 32` with the defaults) to 1, all other reset bits to 0, `busy_o` to 0 and `ch_on_o` to 0.
- R2: Serving an enable for a stopped channel with a linked reset sets that channel's reset bit and raises `busy_o` one cycle after the request is registered. The stop bit still shows "stopped" in that cycle.
- R3: The clock of that channel is ungated exactly `PRE_DLY` cycles after its reset bit was set.
- R4: The reset bit is cleared and `busy_o` falls exactly `POST_DLY` cycles after the ungate.
- R5: A channel without a linked reset is ungated one cycle after its enable request is registered. `busy_o` stays 0 and the reset word does not change.
- R6: An enable for a channel that is already running completes with no change to the reset word and without raising `busy_o`.
- R7: For a normal-polarity channel, a stop bit of 1 means stopped. Enable clears the bit and disable sets it.
- R8: The inverted channel (stop bit 14 by default) is running when its bit is 1. Enable sets the bit and disable clears it.
- R9: A disable changes only the channel's stop bit, one cycle after the request is registered, and never sets a reset bit.
- R10: At most one stop bit changes per cycle. Requests that arrive while `busy_o` is high are held. After the sequence ends they are served one per cycle: all pending disables first, then enables, each group lowest channel first.
- R11: `ch_on_o[i]` is 1 when stop bit i equals its running value and channel i is not the one in an active sequence.
- R12: If enable and disable strobes for one channel arrive in the same cycle, the disable wins. A later strobe cancels a still-pending strobe of the opposite kind for that channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, also the delay timebase |
| rst_i | input | 1 | Synchronous reset, active high |
| en_req_i | input | NCH | One-cycle enable strobes, one per channel |
| dis_req_i | input | NCH | One-cycle disable strobes, one per channel |
| clk_stop_o | output | NCH | Clock-stop control word |
| rst_o | output | NCH | Peripheral reset control word, 1 = in reset |
| ch_on_o | output | NCH | Per-channel running status |
| busy_o | output | 1 | High while a timed enable sequence runs |

## Verification
The bench builds the block with 32 channels, the default linked-reset and polarity masks, `PRE_DLY` = 4 and `POST_DLY` = 10. These short delays let the exact ungate and release cycles of a timed sequence be counted, and let queued requests be issued in the middle of a sequence. Disables and enables are queued behind a busy sequence, so the serving order and the one-bit-per-cycle rule show directly on the stop word. A channel that was enabled and then disabled is re-enabled, so the fresh rise of its reset bit is visible.

// File: rtl/pces_pkg.sv
package pces_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRE  = 2'd1,
        ST_POST = 2'd2
    } seq_st_e;

endpackage

// File: rtl/pces_pick.sv
// Lowest-index set-bit picker.
module pces_pick #(
    parameter int N  = 32,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        any_o = |req_i;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IW'(i);
        end
    end
endmodule

// File: rtl/pces_delay.sv
// Loadable down-counter timing the sequence waits.
module pces_delay #(
    parameter int CW = 8
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          load_i,
    input  logic [CW-1:0] val_i,
    output logic          zero_o
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)            cnt_d = val_i;
        else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) cnt_q <= '0;
        else       cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);

    // R3: an unloaded nonzero count steps down by one each cycle
    p_count_down_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/pces_seq.sv
module pces_seq
    import pces_pkg::*;
#(
    parameter int              NCH      = 32,
    parameter int              PRE_DLY  = 12500,
    parameter int              POST_DLY = 1250000,
    parameter logic [NCH-1:0]  HAS_RST  = 32'h0830_4D9A,
    parameter logic [NCH-1:0]  INV_POL  = 32'h0000_4000,
    parameter int              RST_STEP = 7,
    parameter int              RST_OFS  = 3
) (
    input  logic           clk_i,
    input  logic           rst_i,
    input  logic [NCH-1:0] en_req_i,
    input  logic [NCH-1:0] dis_req_i,
    output logic [NCH-1:0] clk_stop_o,
    output logic [NCH-1:0] rst_o,
    output logic [NCH-1:0] ch_on_o,
    output logic           busy_o
);
    localparam int IW   = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int DMAX = (PRE_DLY > POST_DLY) ? PRE_DLY : POST_DLY;
    localparam int CW   = $clog2(DMAX + 1);

    function automatic logic [NCH*IW-1:0] f_rmap();
        logic [NCH*IW-1:0] m;
        m = '0;
        for (int c = 0; c < NCH; c++) m[c*IW +: IW] = IW'((c * RST_STEP + RST_OFS) % NCH);
        return m;
    endfunction

    function automatic logic [NCH-1:0] f_rinit();
        logic [NCH-1:0] r;
        r = '0;
        for (int c = 0; c < NCH; c++) begin
            if (HAS_RST[c]) r[(c * RST_STEP + RST_OFS) % NCH] = 1'b1;
        end
        return r;
    endfunction

    localparam logic [NCH*IW-1:0] RMAP     = f_rmap();
    localparam logic [NCH-1:0]    RST_INIT = f_rinit();

    typedef struct packed {
        seq_st_e        st;
        logic [IW-1:0]  cur;
        logic [NCH-1:0] stop;
        logic [NCH-1:0] rstw;
        logic [NCH-1:0] en_pend;
        logic [NCH-1:0] dis_pend;
    } regs_t;

    regs_t d, q;

    logic          dis_any, en_any, tmr_zero, tmr_load;
    logic [IW-1:0] dis_idx, en_idx;
    logic [CW-1:0] tmr_val;

    pces_pick #(.N(NCH), .IW(IW)) u_pick_dis (
        .req_i(q.dis_pend), .any_o(dis_any), .idx_o(dis_idx));

    pces_pick #(.N(NCH), .IW(IW)) u_pick_en (
        .req_i(q.en_pend), .any_o(en_any), .idx_o(en_idx));

    pces_delay #(.CW(CW)) u_delay (
        .clk_i(clk_i), .rst_i(rst_i), .load_i(tmr_load),
        .val_i(tmr_val), .zero_o(tmr_zero));

    logic [NCH-1:0] new_en, en_clr, dis_clr;
    logic [IW-1:0]  rb_en, rb_cur;

    assign new_en = en_req_i & ~dis_req_i;
    assign rb_en  = RMAP[en_idx*IW +: IW];
    assign rb_cur = RMAP[q.cur*IW +: IW];

    always_comb begin
        d        = q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        en_clr   = '0;
        dis_clr  = '0;
        case (q.st)
            ST_IDLE: begin
                if (dis_any) begin
                    dis_clr[dis_idx] = 1'b1;
                    d.stop[dis_idx]  = ~INV_POL[dis_idx];
                end else if (en_any) begin
                    en_clr[en_idx] = 1'b1;
                    if (q.stop[en_idx] != INV_POL[en_idx]) begin
                        if (HAS_RST[en_idx]) begin
                            d.rstw[rb_en] = 1'b1;
                            d.st          = ST_PRE;
                            d.cur         = en_idx;
                            tmr_load      = 1'b1;
                            tmr_val       = CW'(PRE_DLY - 1);
                        end else begin
                            d.stop[en_idx] = INV_POL[en_idx];
                        end
                    end
                end
            end
            ST_PRE: begin
                if (tmr_zero) begin
                    d.stop[q.cur] = INV_POL[q.cur];
                    d.st          = ST_POST;
                    tmr_load      = 1'b1;
                    tmr_val       = CW'(POST_DLY - 1);
                end
            end
            ST_POST: begin
                if (tmr_zero) begin
                    d.rstw[rb_cur] = 1'b0;
                    d.st           = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
        d.en_pend  = (q.en_pend & ~en_clr & ~dis_req_i) | new_en;
        d.dis_pend = (q.dis_pend & ~dis_clr & ~new_en) | dis_req_i;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            q.st       <= ST_IDLE;
            q.cur      <= '0;
            q.stop     <= ~INV_POL;
            q.rstw     <= RST_INIT;
            q.en_pend  <= '0;
            q.dis_pend <= '0;
        end else begin
            q <= d;
        end
    end

    logic [NCH-1:0] cur_mask;
    assign cur_mask   = busy_o ? (NCH'(1) << q.cur) : '0;
    assign clk_stop_o = q.stop;
    assign rst_o      = q.rstw;
    assign busy_o     = (q.st != ST_IDLE);
    assign ch_on_o    = ~(q.stop ^ INV_POL) & ~cur_mask;

    // R2, R9: a reset bit only rises as a timed sequence starts
    p_rst_rise_start_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (|(rst_o & ~$past(rst_o))) |-> $rose(busy_o));
    // R2: during the first wait the channel is in reset and still stopped
    p_pre_held_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (q.st == ST_PRE) |-> (q.rstw[rb_cur] && (q.stop[q.cur] != INV_POL[q.cur])));
    // R3: timer expiry in the first wait ungates the channel
    p_ungate_on_expiry_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (q.st == ST_PRE && tmr_zero) |=> (clk_stop_o[q.cur] == INV_POL[q.cur]));
    // R10: one stop bit at most changes per cycle
    p_one_stop_change_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(clk_stop_o ^ $past(clk_stop_o)));
    // R11: the channel in sequence never reports running
    p_hidden_in_seq_r11: assert property (@(posedge clk_i) disable iff (rst_i)
        busy_o |-> !ch_on_o[q.cur]);
endmodule

// File: tb/tb_pces_seq.sv
module tb_pces_seq;
    localparam int          NCH  = 32;
    localparam int          PRE  = 4;
    localparam int          POST = 10;
    localparam logic [31:0] HAS  = 32'h0830_4D9A;
    localparam logic [31:0] INV  = 32'h0000_4000;

    logic        clk_i = 1'b0;
    logic        rst_i = 1'b1;
    logic [31:0] en_req_i = '0, dis_req_i = '0;
    logic [31:0] clk_stop_o, rst_o, ch_on_o;
    logic        busy_o;

    pces_seq #(.NCH(NCH), .PRE_DLY(PRE), .POST_DLY(POST)) dut (
        .clk_i(clk_i), .rst_i(rst_i), .en_req_i(en_req_i), .dis_req_i(dis_req_i),
        .clk_stop_o(clk_stop_o), .rst_o(rst_o), .ch_on_o(ch_on_o), .busy_o(busy_o));

    always #4 clk_i = ~clk_i;

    int errors = 0, checks = 0;
    bit done = 1'b0;

    function automatic int rbit(int ch);
        return (ch * 7 + 3) % 32;
    endfunction

    function automatic logic [31:0] rinit();
        logic [31:0] r = '0;
        for (int c = 0; c < 32; c++) if (HAS[c]) r[rbit(c)] = 1'b1;
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulse(input logic [31:0] en, input logic [31:0] dis);
        @(negedge clk_i);
        en_req_i = en; dis_req_i = dis;
        @(negedge clk_i);
        en_req_i = '0; dis_req_i = '0;
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk_i);
    endtask

    // vector: bit8 = 1 enable / 0 disable, bits 4:0 channel
    localparam logic [8:0] VEC [8] = '{
        9'h100, 9'h101, 9'h10E, 9'h00E, 9'h001, 9'h105, 9'h000, 9'h10B };
    localparam string VREQ [8] = '{ "R5", "R7", "R8", "R8", "R9", "R5", "R7", "R4" };

    logic [31:0] m_stop, m_rst;

    initial begin
        wait_n(5);
        rst_i = 1'b0;
        // R1 reset state
        m_stop = ~INV; m_rst = rinit();
        chk(clk_stop_o == m_stop, "R1 stop", clk_stop_o, m_stop);
        chk(rst_o == m_rst, "R1 reset word", rst_o, m_rst);
        chk(ch_on_o == '0 && !busy_o, "R1 status", ch_on_o, 32'h0);

        for (int v = 0; v < 8; v++) begin
            int ch;
            logic [31:0] prev_rst;
            ch = int'(VEC[v][4:0]);
            prev_rst = rst_o;
            if (VEC[v][8]) pulse(32'h1 << ch, '0);
            else           pulse('0, 32'h1 << ch);
            wait_n(PRE + POST + 6);
            if (VEC[v][8]) begin
                m_stop[ch] = INV[ch];
                if (HAS[ch]) m_rst[rbit(ch)] = 1'b0;
            end else begin
                m_stop[ch] = ~INV[ch];
                chk(rst_o == prev_rst, "R9 disable left reset", rst_o, prev_rst);
            end
            chk(clk_stop_o == m_stop, VREQ[v], clk_stop_o, m_stop);
            chk(rst_o == m_rst, VREQ[v], rst_o, m_rst);
            chk(ch_on_o == ~(m_stop ^ INV), "R11 status", ch_on_o, ~(m_stop ^ INV));
        end

        // R5: unlinked enable timing (ch0 currently stopped)
        begin
            logic [31:0] r0;
            r0 = rst_o;
            pulse(32'h1, '0);
            @(negedge clk_i);
            chk(clk_stop_o[0] == 1'b0 && !busy_o && rst_o == r0, "R5 one-cycle ungate",
                {clk_stop_o[0], busy_o}, 32'h0);
        end

        // R2/R3/R4/R11: re-enable ch1 (reset bit 10), timed
        begin
            int n_set, n_ungate, n_rel;
            n_set = -1; n_ungate = -1; n_rel = -1;
            pulse(32'h2, '0);
            for (int n = 1; n <= 30; n++) begin
                @(negedge clk_i);
                if (n_set < 0 && rst_o[10]) begin
                    n_set = n;
                    chk(busy_o && clk_stop_o[1], "R2 reset before ungate", {busy_o, clk_stop_o[1]}, 32'h3);
                end
                if (n_ungate < 0 && !clk_stop_o[1]) begin
                    n_ungate = n;
                    chk(rst_o[10] && !ch_on_o[1], "R11 hidden while in reset", {rst_o[10], ch_on_o[1]}, 32'h2);
                end
                if (n_set > 0 && n_rel < 0 && !rst_o[10]) begin
                    n_rel = n;
                    chk(!busy_o && ch_on_o[1], "R4 busy falls with release", {busy_o, ch_on_o[1]}, 32'h1);
                end
            end
            chk(n_set == 1, "R2 set cycle", n_set, 1);
            chk(n_ungate == 1 + PRE, "R3 ungate cycle", n_ungate, 1 + PRE);
            chk(n_rel == 1 + PRE + POST, "R4 release cycle", n_rel, 1 + PRE + POST);
        end

        // R6: enable of running ch1 again
        begin
            logic [31:0] r0;
            bit seen;
            r0 = rst_o; seen = 0;
            pulse(32'h2, '0);
            for (int i = 0; i < 20; i++) begin
                @(negedge clk_i);
                if (busy_o || rst_o != r0) seen = 1;
            end
            chk(!seen && !clk_stop_o[1], "R6 no reset pulse", rst_o, r0);
        end

        // R10: queue behind a sequence; ch5 running, ch2 stopped
        begin
            int k;
            pulse(32'h10, '0);
            pulse(32'h4, 32'h20);
            k = 0;
            while (busy_o && k < 100) begin @(negedge clk_i); k++; end
            chk(clk_stop_o[5] == 1'b0 && clk_stop_o[2] == 1'b1, "R10 held while busy",
                {clk_stop_o[5], clk_stop_o[2]}, 32'h1);
            @(negedge clk_i);
            chk(clk_stop_o[5] == 1'b1 && clk_stop_o[2] == 1'b1, "R10 disable first",
                {clk_stop_o[5], clk_stop_o[2]}, 32'h3);
            @(negedge clk_i);
            chk(clk_stop_o[2] == 1'b0, "R10 enable next", clk_stop_o[2], 32'h0);
        end

        // R12: simultaneous strobes on ch6, disable wins
        pulse(32'h40, '0);
        wait_n(3);
        chk(clk_stop_o[6] == 1'b0, "R7 ch6 enabled", clk_stop_o[6], 32'h0);
        pulse(32'h40, 32'h40);
        wait_n(3);
        chk(clk_stop_o[6] == 1'b1, "R12 same-cycle disable wins", clk_stop_o[6], 32'h1);

        // R12: later disable cancels pending enable of ch9 queued behind ch7
        pulse(32'h80, '0);
        pulse(32'h200, '0);
        pulse('0, 32'h200);
        wait_n(PRE + POST + 8);
        chk(clk_stop_o[9] == 1'b1, "R12 pending enable cancelled", clk_stop_o[9], 32'h1);
        chk(clk_stop_o[7] == 1'b0 && rst_o[rbit(7)] == 1'b0, "R4 ch7 done",
            {clk_stop_o[7], rst_o[rbit(7)]}, 32'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wait_n(20000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule